// File: doc/BRIEF.md
# Plug-and-Play Device Configuration Decoder

This block holds the configuration state of one logical device that sits on a host I/O bus, and decodes host I/O addresses against that state. A configuration front end, not part of this block, presents an 8-bit register index, write data and a write strobe. Through this port software sets the device's I/O base addresses, its interrupt number, wake enable and trigger type, its two DMA channel numbers, a bank of vendor-defined control bytes, and an activation register that holds the device enable and a lock bit. Reads return the addressed register through a combinational path.

The address side is fully combinational. A 16-bit host I/O address is masked down to the device's range size, which is a parameter of 1 to 32 bytes, and compared against each programmed base address. A match on an enabled device with a non-zero base raises that descriptor's select output and passes the low address bits out as the register offset. The parameters also set a restricted-range mode that keeps the device below 0x0800, an optional second descriptor, and a legacy mode that gives the device a fixed base address and IRQ at reset.

There are two synchronous active-low resets. The hardware reset returns every register to its default. The software reset does the same, except that once the lock bit is set it leaves the resource registers and the lock bit as they are.

Top module: `pnp_cfg_dec`

## Requirements
- R1: After hardware reset, every configuration index reads 0x00. The exceptions apply only in legacy mode: the base address at 0x60/0x61 reads the legacy base, and 0x70 bits 3:0 read the legacy IRQ.
- R2: The base address is written as a high byte at index 0x60 and a low byte at 0x61. The second descriptor, when present, uses 0x62 (high) and 0x63 (low). Base bits below log2 of the range size always read 0. In restricted mode, bits 15:11 also always read 0.
- R3: Index 0x30 bit 0 is the device enable and drives dev_en. Bit 7 is the lock. All other bits of 0x30 read 0.
- R4: Index 0x70 bits 3:0 hold the IRQ number and bit 4 holds the wake enable. Index 0x71 bits 1:0 hold the interrupt type. All other bits read 0, and the fields drive irq_num, irq_wake and irq_type.
- R5: Indices 0x74 and 0x75 bits 2:0 hold DMA channels 0 and 1, which drive dma0 and dma1. Bits 7:3 read 0.
- R6: Vendor control bytes k = 0 to VND_REGS-1 sit at index 0xF0+k. All 8 bits are writable, and byte k appears on vnd_ctl bits 8k+7:8k.
- R7: Any index not named in R2 to R6 reads 0x00, and a write to it leaves every implemented register unchanged. When the second descriptor is absent, 0x62/0x63 count as unimplemented.
- R8: sel0 is 1 exactly when dev_en is 1, base0 is non-zero, and (io_addr AND NOT(2^RANGE_LOG2-1)) equals base0. sel1 follows the same rule with base1, and it stays 0 when the second descriptor is absent.
- R9: io_offset equals io_addr bits RANGE_LOG2-1:0, zero-extended, while sel0 or sel1 is 1. Otherwise io_offset is 0.
- R10: While the lock bit is 1, writes to indices 0x60 to 0x75 are ignored, and writing 0 to bit 7 of 0x30 does not clear the lock. Only the hardware reset clears it.
- R11: A software reset clears dev_en and the vendor bytes. If the device is locked, the registers at 0x60 to 0x75 and the lock bit keep their values. If it is unlocked, those registers return to their R1 defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sw_rst_n | input | 1 | Synchronous active-low software reset |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_idx |
| io_addr | input | 16 | Host I/O address to decode |
| sel0 | output | 1 | Address falls in the first descriptor range |
| sel1 | output | 1 | Address falls in the second descriptor range |
| io_offset | output | 5 | Register offset inside the selected range |
| dev_en | output | 1 | Device enable |
| irq_num | output | 4 | Interrupt number |
| irq_wake | output | 1 | Wake-up on interrupt enable |
| irq_type | output | 2 | Interrupt type and polarity |
| dma0 | output | 3 | First DMA channel |
| dma1 | output | 3 | Second DMA channel |
| vnd_ctl | output | VND_REGS*8 | Vendor control bytes |

## Verification
The hardest state to reach from the ports is a software reset that arrives while the device is locked. It must keep some registers and clear others, and it must do so differently in legacy and non-legacy devices. The stimulus programs all the resources, sets the lock, tries writes that must be refused, pulses the software reset, and then reads back every one of the 256 indices. The same is done once with the device unlocked. Two instances run side by side on the same stimulus, one restricted with two descriptors and one legacy with a single descriptor. Each base byte is swept through all 256 values, and io_addr is swept through the whole 16-bit space.

// File: rtl/pnp_cfg_pkg.sv
// Shared index map, field positions and helpers for the device
// configuration decoder. Assumes 8-bit configuration indices.
package pnp_cfg_pkg;

    localparam logic [7:0] IDX_ACT   = 8'h30;
    localparam logic [7:0] IDX_B0_HI = 8'h60;
    localparam logic [7:0] IDX_B0_LO = 8'h61;
    localparam logic [7:0] IDX_B1_HI = 8'h62;
    localparam logic [7:0] IDX_B1_LO = 8'h63;
    localparam logic [7:0] IDX_IRQ   = 8'h70;
    localparam logic [7:0] IDX_ITYP  = 8'h71;
    localparam logic [7:0] IDX_DMA0  = 8'h74;
    localparam logic [7:0] IDX_DMA1  = 8'h75;
    localparam logic [7:0] IDX_VND0  = 8'hF0;

    // First and last index covered by the lock
    localparam logic [7:0] IDX_LOCK_LO = 8'h60;
    localparam logic [7:0] IDX_LOCK_HI = 8'h75;

    localparam int ACT_EN_BIT   = 0;
    localparam int ACT_LOCK_BIT = 7;
    localparam int OFF_W        = 5;

    // Interrupt programming bundle
    typedef struct packed {
        logic [3:0] num;
        logic       wake;
        logic [1:0] kind;
    } irq_cfg_t;

    // Writable-bit mask of a base address for the given range and mode
    function automatic logic [15:0] base_wmask(input int range_log2, input bit restricted);
        logic [15:0] m;
        m = 16'hFFFF << range_log2;
        if (restricted) m = m & 16'h07FF;
        return m;
    endfunction

endpackage

// File: rtl/pnp_io_match.sv
// Address comparator for one I/O descriptor. It drops the low
// RANGE_LOG2 address bits and compares the rest with an aligned base.
// Assumes the base already has its low bits cleared.
module pnp_io_match #(
    parameter int RANGE_LOG2 = 3
) (
    input  logic [15:0] io_addr,
    input  logic [15:0] base,
    input  logic        enable,
    output logic        hit
);

    localparam logic [15:0] ADDR_MASK = 16'hFFFF << RANGE_LOG2;

    // Hit when enabled, base programmed and upper bits equal
    always_comb begin
        hit = enable && (base != 16'h0000) && ((io_addr & ADDR_MASK) == base);
    end

endmodule

// File: rtl/pnp_cfg_regs.sv
// Configuration register file: activation/lock, base addresses,
// interrupt, DMA and vendor bytes, with hardware and software reset.
// Assumes a single write strobe and a combinational read path.
module pnp_cfg_regs
    import pnp_cfg_pkg::*;
#(
    parameter int          RANGE_LOG2  = 3,
    parameter bit          RESTRICTED  = 1'b0,
    parameter bit          TWO_BASES   = 1'b1,
    parameter bit          LEGACY      = 1'b0,
    parameter logic [15:0] LEGACY_BASE = 16'h0000,
    parameter logic [3:0]  LEGACY_IRQ  = 4'd0,
    parameter int          VND_REGS    = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sw_rst_n,
    input  logic [7:0]            cfg_idx,
    input  logic                  cfg_wr,
    input  logic [7:0]            cfg_wdata,
    output logic [7:0]            cfg_rdata,
    output logic                  dev_en,
    output logic                  cfg_lock,
    output logic [15:0]           base0,
    output logic [15:0]           base1,
    output irq_cfg_t              irq_cfg,
    output logic [2:0]            dma0,
    output logic [2:0]            dma1,
    output logic [VND_REGS*8-1:0] vnd_ctl
);

    localparam logic [15:0] WMASK     = base_wmask(RANGE_LOG2, RESTRICTED);
    localparam logic [15:0] BASE0_RST = LEGACY ? (LEGACY_BASE & WMASK) : 16'h0000;
    localparam logic [3:0]  IRQ_RST   = LEGACY ? LEGACY_IRQ : 4'd0;

    logic [7:0] vnd_q [VND_REGS];
    logic       res_wr;

    // Resource writes are allowed only while unlocked
    assign res_wr = cfg_wr && !cfg_lock;

    // Activation register: enable clears on either reset, lock only on hardware reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_en   <= 1'b0;
            cfg_lock <= 1'b0;
        end else if (!sw_rst_n) begin
            dev_en   <= 1'b0;
        end else if (cfg_wr && cfg_idx == IDX_ACT) begin
            dev_en   <= cfg_wdata[ACT_EN_BIT];
            cfg_lock <= cfg_lock | cfg_wdata[ACT_LOCK_BIT];
        end
    end

    // Resource registers: defaults on reset, kept across soft reset when locked
    always_ff @(posedge clk) begin
        if (!rst_n || (!sw_rst_n && !cfg_lock)) begin
            base0   <= BASE0_RST;
            base1   <= 16'h0000;
            irq_cfg <= '{num: IRQ_RST, wake: 1'b0, kind: 2'b00};
            dma0    <= 3'd0;
            dma1    <= 3'd0;
        end else if (sw_rst_n && res_wr) begin
            case (cfg_idx)
                IDX_B0_HI: base0[15:8] <= cfg_wdata & WMASK[15:8];
                IDX_B0_LO: base0[7:0]  <= cfg_wdata & WMASK[7:0];
                IDX_B1_HI: if (TWO_BASES) base1[15:8] <= cfg_wdata & WMASK[15:8];
                IDX_B1_LO: if (TWO_BASES) base1[7:0]  <= cfg_wdata & WMASK[7:0];
                IDX_IRQ: begin
                    irq_cfg.num  <= cfg_wdata[3:0];
                    irq_cfg.wake <= cfg_wdata[4];
                end
                IDX_ITYP:  irq_cfg.kind <= cfg_wdata[1:0];
                IDX_DMA0:  dma0 <= cfg_wdata[2:0];
                IDX_DMA1:  dma1 <= cfg_wdata[2:0];
                default: ;
            endcase
        end
    end

    // One byte register per vendor index, cleared by either reset
    for (genvar k = 0; k < VND_REGS; k++) begin : g_vnd
        localparam logic [7:0] MY_IDX = IDX_VND0 + 8'(k);
        always_ff @(posedge clk) begin
            if (!rst_n || !sw_rst_n) begin
                vnd_q[k] <= 8'h00;
            end else if (cfg_wr && cfg_idx == MY_IDX) begin
                vnd_q[k] <= cfg_wdata;
            end
        end
        assign vnd_ctl[8*k +: 8] = vnd_q[k];
    end

    // Read multiplexer; unimplemented indices read zero
    always_comb begin
        cfg_rdata = 8'h00;
        case (cfg_idx)
            IDX_ACT:   cfg_rdata = {cfg_lock, 6'b0, dev_en};
            IDX_B0_HI: cfg_rdata = base0[15:8];
            IDX_B0_LO: cfg_rdata = base0[7:0];
            IDX_B1_HI: cfg_rdata = TWO_BASES ? base1[15:8] : 8'h00;
            IDX_B1_LO: cfg_rdata = TWO_BASES ? base1[7:0] : 8'h00;
            IDX_IRQ:   cfg_rdata = {3'b0, irq_cfg.wake, irq_cfg.num};
            IDX_ITYP:  cfg_rdata = {6'b0, irq_cfg.kind};
            IDX_DMA0:  cfg_rdata = {5'b0, dma0};
            IDX_DMA1:  cfg_rdata = {5'b0, dma1};
            default: begin
                for (int k = 0; k < VND_REGS; k++) begin
                    if (cfg_idx == IDX_VND0 + 8'(k)) cfg_rdata = vnd_q[k];
                end
            end
        endcase
    end

endmodule

// File: rtl/pnp_cfg_dec.sv
// Top of the device configuration decoder: register file plus one
// address matcher per descriptor and the offset output.
// Assumes RANGE_LOG2 in 0..5 and VND_REGS in 1..16.
module pnp_cfg_dec
    import pnp_cfg_pkg::*;
#(
    parameter int          RANGE_LOG2  = 3,
    parameter bit          RESTRICTED  = 1'b1,
    parameter bit          TWO_BASES   = 1'b1,
    parameter bit          LEGACY      = 1'b0,
    parameter logic [15:0] LEGACY_BASE = 16'h0000,
    parameter logic [3:0]  LEGACY_IRQ  = 4'd0,
    parameter int          VND_REGS    = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sw_rst_n,
    input  logic [7:0]            cfg_idx,
    input  logic                  cfg_wr,
    input  logic [7:0]            cfg_wdata,
    output logic [7:0]            cfg_rdata,
    input  logic [15:0]           io_addr,
    output logic                  sel0,
    output logic                  sel1,
    output logic [4:0]            io_offset,
    output logic                  dev_en,
    output logic [3:0]            irq_num,
    output logic                  irq_wake,
    output logic [1:0]            irq_type,
    output logic [2:0]            dma0,
    output logic [2:0]            dma1,
    output logic [VND_REGS*8-1:0] vnd_ctl
);

    localparam int         NUM_DESC = TWO_BASES ? 2 : 1;
    localparam logic [4:0] OFF_MASK = 5'((1 << RANGE_LOG2) - 1);

    logic        cfg_lock;
    logic [15:0] base0;
    logic [15:0] base1;
    logic [15:0] base_arr [2];
    logic [1:0]  hit;
    irq_cfg_t    irq_cfg;

    pnp_cfg_regs #(
        .RANGE_LOG2 (RANGE_LOG2),
        .RESTRICTED (RESTRICTED),
        .TWO_BASES  (TWO_BASES),
        .LEGACY     (LEGACY),
        .LEGACY_BASE(LEGACY_BASE),
        .LEGACY_IRQ (LEGACY_IRQ),
        .VND_REGS   (VND_REGS)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst_n (sw_rst_n),
        .cfg_idx  (cfg_idx),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .dev_en   (dev_en),
        .cfg_lock (cfg_lock),
        .base0    (base0),
        .base1    (base1),
        .irq_cfg  (irq_cfg),
        .dma0     (dma0),
        .dma1     (dma1),
        .vnd_ctl  (vnd_ctl)
    );

    assign base_arr[0] = base0;
    assign base_arr[1] = base1;

    // One comparator per present descriptor, absent ones never hit
    for (genvar d = 0; d < 2; d++) begin : g_desc
        if (d < NUM_DESC) begin : g_on
            pnp_io_match #(.RANGE_LOG2(RANGE_LOG2)) match_i (
                .io_addr(io_addr),
                .base   (base_arr[d]),
                .enable (dev_en),
                .hit    (hit[d])
            );
        end else begin : g_off
            assign hit[d] = 1'b0;
        end
    end

    // Select and offset outputs
    always_comb begin
        sel0      = hit[0];
        sel1      = hit[1];
        io_offset = (hit != 2'b00) ? (io_addr[4:0] & OFF_MASK) : 5'd0;
    end

    assign irq_num  = irq_cfg.num;
    assign irq_wake = irq_cfg.wake;
    assign irq_type = irq_cfg.kind;

endmodule

// File: rtl/pnp_cfg_chk.sv
// Assertion checker for pnp_cfg_dec, attached by bind below.
// Observes ports plus the lock bit and the first base register.
module pnp_cfg_chk #(
    parameter int RANGE_LOG2 = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sw_rst_n,
    input logic [7:0]  cfg_idx,
    input logic [7:0]  cfg_rdata,
    input logic        sel0,
    input logic        sel1,
    input logic [4:0]  io_offset,
    input logic        dev_en,
    input logic        cfg_lock,
    input logic [15:0] base0
);

    localparam logic [7:0] LOW_MASK = 8'((1 << RANGE_LOG2) - 1);

    a_r8_sel_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0 || sel1) |-> dev_en);

    a_r9_offset_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel0 || sel1) |-> (io_offset == 5'd0));

    a_r2_low_base_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == 8'h61) |-> ((cfg_rdata & LOW_MASK) == 8'h00));

    a_r10_lock_freezes_base: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lock && $past(cfg_lock)) |-> $stable(base0));

    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_lock) && $past(rst_n)) |-> cfg_lock);

    a_r11_soft_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rst_n |=> !dev_en);

endmodule

bind pnp_cfg_dec pnp_cfg_chk #(.RANGE_LOG2(RANGE_LOG2)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_rst_n (sw_rst_n),
    .cfg_idx  (cfg_idx),
    .cfg_rdata(cfg_rdata),
    .sel0     (sel0),
    .sel1     (sel1),
    .io_offset(io_offset),
    .dev_en   (dev_en),
    .cfg_lock (cfg_lock),
    .base0    (base0)
);

// File: tb/pnp_cfg_dec_tb_top.sv
// Bench: a restricted two-descriptor instance and a legacy single-
// descriptor instance share stimulus; a per-index byte model predicts reads.
module pnp_cfg_dec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst_n = 1'b1;
    logic [7:0]  cfg_idx = 8'h00;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [15:0] io_addr = 16'h0000;

    logic [7:0]  rd_a, rd_b;
    logic        s0_a, s1_a, s0_b, s1_b, en_a, en_b, wk_a, wk_b;
    logic [4:0]  off_a, off_b;
    logic [3:0]  irq_a, irq_b;
    logic [1:0]  ty_a, ty_b;
    logic [2:0]  d0_a, d1_a, d0_b, d1_b;
    logic [79:0] vnd_a, vnd_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_a [256];
    logic [7:0] exp_b [256];

    always #5 clk = ~clk;

    pnp_cfg_dec #(.RANGE_LOG2(3), .RESTRICTED(1'b1), .TWO_BASES(1'b1), .LEGACY(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_rst_n(sw_rst_n), .cfg_idx(cfg_idx), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd_a), .io_addr(io_addr), .sel0(s0_a), .sel1(s1_a),
        .io_offset(off_a), .dev_en(en_a), .irq_num(irq_a), .irq_wake(wk_a), .irq_type(ty_a),
        .dma0(d0_a), .dma1(d1_a), .vnd_ctl(vnd_a));

    pnp_cfg_dec #(.RANGE_LOG2(2), .RESTRICTED(1'b0), .TWO_BASES(1'b0), .LEGACY(1'b1),
                  .LEGACY_BASE(16'h02F8), .LEGACY_IRQ(4'd3)) dut_leg_i (
        .clk(clk), .rst_n(rst_n), .sw_rst_n(sw_rst_n), .cfg_idx(cfg_idx), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd_b), .io_addr(io_addr), .sel0(s0_b), .sel1(s1_b),
        .io_offset(off_b), .dev_en(en_b), .irq_num(irq_b), .irq_wake(wk_b), .irq_type(ty_b),
        .dma0(d0_b), .dma1(d1_b), .vnd_ctl(vnd_b));

    // Writable bits per index for each instance (0 = unimplemented)
    function automatic logic [7:0] mask_of(input int idx, input bit leg);
        if (idx == 'h30) return 8'h81;
        if (idx == 'h60) return leg ? 8'hFF : 8'h07;
        if (idx == 'h61) return leg ? 8'hFC : 8'hF8;
        if (idx == 'h62) return leg ? 8'h00 : 8'h07;
        if (idx == 'h63) return leg ? 8'h00 : 8'hF8;
        if (idx == 'h70) return 8'h1F;
        if (idx == 'h71) return 8'h03;
        if (idx == 'h74 || idx == 'h75) return 8'h07;
        if (idx >= 'hF0 && idx <= 'hF9) return 8'hFF;
        return 8'h00;
    endfunction

    function automatic logic [7:0] dflt_of(input int idx, input bit leg);
        if (leg && idx == 'h60) return 8'h02;
        if (leg && idx == 'h61) return 8'hF8;
        if (leg && idx == 'h70) return 8'h03;
        return 8'h00;
    endfunction

    function automatic string req_of(input int idx);
        if (idx == 'h30) return "R3";
        if (idx >= 'h60 && idx <= 'h63) return "R2";
        if (idx == 'h70 || idx == 'h71) return "R4";
        if (idx == 'h74 || idx == 'h75) return "R5";
        if (idx >= 'hF0 && idx <= 'hF9) return "R6";
        return "R7";
    endfunction

    function automatic logic [7:0] upd(input logic [7:0] old, input int idx, input logic [7:0] v,
                                       input bit leg, input bit lk);
        logic [7:0] r;
        if (lk && idx >= 'h60 && idx <= 'h75) return old;
        r = v & mask_of(idx, leg);
        if (idx == 'h30) r[7] = r[7] | old[7];
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic model_reset(input bit hard);
        for (int i = 0; i < 256; i++) begin
            bit la, lb;
            la = exp_a['h30][7] && !hard;
            lb = exp_b['h30][7] && !hard;
            if (!(la && i >= 'h60 && i <= 'h75)) exp_a[i] = (i == 'h30 && la) ? 8'h80 : dflt_of(i, 1'b0);
            if (!(lb && i >= 'h60 && i <= 'h75)) exp_b[i] = (i == 'h30 && lb) ? 8'h80 : dflt_of(i, 1'b1);
        end
    endtask

    task automatic wr(input int idx, input logic [7:0] v);
        @(negedge clk);
        cfg_idx = idx[7:0]; cfg_wdata = v; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        exp_a[idx] = upd(exp_a[idx], idx, v, 1'b0, exp_a['h30][7]);
        exp_b[idx] = upd(exp_b[idx], idx, v, 1'b1, exp_b['h30][7]);
    endtask

    task automatic rd_chk(input int idx, input string tag);
        cfg_idx = idx[7:0];
        #1;
        chk(tag == "" ? req_of(idx) : tag, rd_a, exp_a[idx]);
        chk(tag == "" ? req_of(idx) : tag, rd_b, exp_b[idx]);
    endtask

    task automatic verify_all(input string tag);
        for (int i = 0; i < 256; i++) rd_chk(i, tag);
    endtask

    // Port-level view of the programmed fields
    task automatic chk_fields(input string tag);
        chk({tag, "/R3 en"}, en_a, exp_a['h30][0]);
        chk({tag, "/R3 en"}, en_b, exp_b['h30][0]);
        chk({tag, "/R4 irq"}, {wk_a, irq_a}, exp_a['h70][4:0]);
        chk({tag, "/R4 irq"}, {wk_b, irq_b}, exp_b['h70][4:0]);
        chk({tag, "/R4 type"}, ty_a, exp_a['h71][1:0]);
        chk({tag, "/R5 dma"}, {d1_a, d0_a}, {exp_a['h75][2:0], exp_a['h74][2:0]});
        chk({tag, "/R5 dma"}, {d1_b, d0_b}, {exp_b['h75][2:0], exp_b['h74][2:0]});
        for (int k = 0; k < 10; k++) begin
            chk({tag, "/R6 vnd"}, vnd_a[8*k +: 8], exp_a['hF0 + k]);
            chk({tag, "/R6 vnd"}, vnd_b[8*k +: 8], exp_b['hF0 + k]);
        end
    endtask

    task automatic soft_reset();
        @(negedge clk);
        sw_rst_n = 1'b0;
        @(negedge clk);
        sw_rst_n = 1'b1;
        model_reset(1'b0);
    endtask

    // Decode check of one address against the model bases
    task automatic dec_chk(input int a, input string tag);
        logic [15:0] b0a, b1a, b0b, aa;
        bit ea, eb, xs0a, xs1a, xs0b;
        aa  = a[15:0];
        b0a = {exp_a['h60], exp_a['h61]};
        b1a = {exp_a['h62], exp_a['h63]};
        b0b = {exp_b['h60], exp_b['h61]};
        ea  = exp_a['h30][0];
        eb  = exp_b['h30][0];
        io_addr = aa;
        #1;
        xs0a = ea && b0a != 0 && (aa & 16'hFFF8) == b0a;
        xs1a = ea && b1a != 0 && (aa & 16'hFFF8) == b1a;
        xs0b = eb && b0b != 0 && (aa & 16'hFFFC) == b0b;
        chk({tag, " R8 sel0"}, s0_a, xs0a);
        chk({tag, " R8 sel1"}, s1_a, xs1a);
        chk({tag, " R8 leg sel"}, {s1_b, s0_b}, {1'b0, xs0b});
        chk({tag, " R9 off"}, off_a, (xs0a || xs1a) ? int'(aa[2:0]) : 0);
        chk({tag, " R9 leg off"}, off_b, xs0b ? int'(aa[1:0]) : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin exp_a[i] = 8'h00; exp_b[i] = 8'h00; end
        model_reset(1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: defaults after hardware reset, including legacy resources
        verify_all("R1");
        chk_fields("R1");
        chk("R1 sel idle", {s0_a, s1_a, s0_b, s1_b}, 0);

        // R2: every byte value through each base index
        for (int v = 0; v < 256; v++) begin
            for (int idx = 'h60; idx <= 'h63; idx++) begin
                wr(idx, v[7:0]);
                rd_chk(idx, "R2");
            end
        end

        // R3: activation bits, lock left clear
        wr('h30, 8'h7F); rd_chk('h30, "R3"); chk_fields("R3");
        wr('h30, 8'h00); rd_chk('h30, "R3"); chk_fields("R3");

        // R4, R5: field sweeps with port views
        for (int v = 0; v < 256; v += 7) begin
            wr('h70, v[7:0]); wr('h71, ~v[7:0]);
            wr('h74, v[7:0]); wr('h75, 8'(v + 3));
            rd_chk('h70, "R4"); rd_chk('h71, "R4");
            rd_chk('h74, "R5"); rd_chk('h75, "R5");
            chk_fields("R4R5");
        end

        // R6: vendor bytes
        for (int k = 0; k < 10; k++) wr('hF0 + k, 8'(k * 37 + 5));
        verify_all("");
        chk_fields("R6");

        // R7: writes to every unimplemented index must change nothing
        for (int i = 0; i < 256; i++) begin
            if (mask_of(i, 1'b0) == 8'h00) begin
                @(negedge clk);
                cfg_idx = i[7:0]; cfg_wdata = 8'hFF; cfg_wr = 1'b1;
                @(negedge clk);
                cfg_wr = 1'b0;
            end
        end
        verify_all("R7");
        chk_fields("R7");

        // R8, R9: full address sweep with both descriptors programmed
        wr('h60, 8'h02); wr('h61, 8'h38);
        wr('h62, 8'h06); wr('h63, 8'h40);
        wr('h30, 8'h01);
        for (int a = 0; a < 65536; a++) dec_chk(a, "sweep");

        // R8: second base zero never selects
        wr('h62, 8'h00); wr('h63, 8'h00);
        for (int a = 0; a < 16; a++) dec_chk(a, "zero base");
        // R8: disabled device never selects
        wr('h62, 8'h06); wr('h63, 8'h40);
        wr('h30, 8'h00);
        for (int a = 'h0230; a < 'h0248; a++) dec_chk(a, "disabled");
        for (int a = 'h0640; a < 'h0648; a++) dec_chk(a, "disabled");

        // R11: soft reset while unlocked returns resources to defaults
        wr('h30, 8'h01);
        soft_reset();
        verify_all("R11");
        chk_fields("R11");

        // R10: program, lock, then attempt refused writes
        wr('h60, 8'h03); wr('h61, 8'h10); wr('h62, 8'h05); wr('h63, 8'h28);
        wr('h70, 8'h15); wr('h71, 8'h02); wr('h74, 8'h06); wr('h75, 8'h01);
        wr('hF3, 8'hA5);
        wr('h30, 8'h81);
        wr('h60, 8'h01); wr('h61, 8'hF0); wr('h63, 8'h00);
        wr('h70, 8'h0A); wr('h71, 8'h01); wr('h74, 8'h02);
        wr('h30, 8'h01);
        verify_all("R10");
        chk_fields("R10");
        wr('h30, 8'h00);
        chk("R10 lock sticky", rd_a, 8'h80);
        dec_chk('h0310, "locked");

        // R11: soft reset while locked keeps resources and lock
        wr('h30, 8'h01); wr('hF1, 8'h3C);
        soft_reset();
        verify_all("R11");
        chk_fields("R11");

        // R1: hardware reset clears the lock and everything else
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset(1'b1);
        verify_all("R1");
        chk_fields("R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule